// File: doc/BRIEF.md
# Slot-Masked TDM Serial Transmitter

This block is the transmit side of a network-mode time-division-multiplexed serial port. A bit clock, delivered as a one-cycle strobe `bit_tick` in the system clock domain, paces the output. Every frame holds `num_slots` words of `WORD_BITS` bits, sent MSB first. The block drives a frame sync that is one word long and high for the whole of slot 0. Each slot has a bit in `slot_mask` that says whether the slot belongs to this transmitter. On slots that are switched off, the data line is released (`sdo_oe` low) so that another device can drive it.

A host writes the next word through `wr_data`/`wdata`. It may instead strobe `wr_slot`, which claims the coming slot but keeps the line released. The block makes its choice for the next slot at each word boundary, and the choice is held by a four-state machine:
- **ST_IDLE**: entered after reset. It leaves on the first `bit_tick`, which starts slot 0.
- **ST_DRIVE**: a fresh word is loaded. It is also entered on an underrun, where the stale word is loaded again and `tue` is set.
- **ST_HOLD**: the slot is enabled, but only the slot register was written, so the line stays released.
- **ST_MUTE**: the slot is masked off.

Every boundary moves the machine into one of DRIVE, HOLD or MUTE. It stays there until the next boundary. An enabled slot raises the transmit-empty flag `tde`, and `irq` carries `tde` when `tie` is set. Either host write clears `tde`. The underrun flag `tue` stays set until a status read (`rd_status`) is followed by a data write.

Top module: `tdm_slot_tx`

## Requirements
- R1: While reset is held and right after it is released, `sdo_oe`, `sdo`, `fsync`, `tde`, `tue` and `irq` are all 0.
- R2: The first `bit_tick` after reset starts slot 0. Each slot lasts exactly `WORD_BITS` ticks, and the slot index wraps to 0 after slot `num_slots`-1. `fsync` is 1 for the whole of slot 0 and 0 for every other slot.
- R3: For a slot whose `slot_mask` bit is 0, `sdo_oe` and `sdo` stay 0 for the whole slot. `tde` and `tue` do not change, and a host write made before the slot stays pending for the next enabled slot.
- R4: For an enabled slot with a data write pending, the data register value appears on `sdo` MSB first, one bit per tick, with `sdo_oe` = 1. Each bit is visible in the clock cycle after its tick.
- R5: At the start of every enabled slot, `tde` becomes 1. `irq` equals `tde` while `tie` = 1 and is 0 while `tie` = 0.
- R6: A `wr_data` or `wr_slot` strobe sets `tde` to 0 in the next cycle.
- R7: If only `wr_slot` was strobed since the last enabled slot, the next enabled slot keeps `sdo_oe` = 0 and does not set `tue`.
- R8: If neither register was written since the last enabled slot, the next enabled slot sets `tue`, drives `sdo_oe` = 1 and sends the current data register value again.
- R9: `tue` is cleared only by a `wr_data` that follows a `rd_status` made while `tue` was 1. A `wr_data` with no such read before it leaves `tue` at 1.
- R10: If both `wr_data` and `wr_slot` were strobed before an enabled slot, the data write wins and the slot is driven with the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe marking a rising bit-clock edge |
| num_slots | input | $clog2(MAX_SLOTS+1) | Slots per frame, 1..MAX_SLOTS |
| slot_mask | input | MAX_SLOTS | Per-slot enable; bit n enables slot n |
| tie | input | 1 | Enable for the transmit-empty interrupt |
| wr_data | input | 1 | Write strobe for the transmit data register |
| wdata | input | WORD_BITS | Word to write into the data register |
| wr_slot | input | 1 | Write strobe for the time-slot register (claims slot, line stays released) |
| rd_status | input | 1 | Status read strobe; arms the underrun clear |
| sdo | output | 1 | Serial data; 0 whenever the line is released |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| fsync | output | 1 | Word-length frame sync, high during slot 0 |
| tde | output | 1 | Transmit-empty flag |
| tue | output | 1 | Transmit-underrun flag |
| irq | output | 1 | Transmit interrupt request |

## Verification
The bench uses the default `MAX_SLOTS` = 8 and `WORD_BITS` = 8, and drives it with frame lengths of 5, 3 and 1 slots. For each frame length it sweeps every mask pattern, which includes the 5-slot frame with only slots 0 and 3 enabled. Each pattern runs two full frames after a reset. This covers slot wrap at every length, back-to-back enabled and masked slots, and writes that stay pending across masked slots. A fixed arithmetic schedule varies the host action in each slot: nothing, a data write, a slot write, both together, a read then a write, or a read alone. Together these reach every exit of the state machine, underruns, stale-word resends, and both the cleared and the sticky underrun flag.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_MUTE  = 2'd2,
        ST_HOLD  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/tdm_tx_seq.sv
module tdm_tx_seq #(
    parameter int MAX_SLOTS = 8,
    parameter int WORD_BITS = 8,
    localparam int SLOT_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int CNT_W  = $clog2(MAX_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [CNT_W-1:0]  num_slots,
    output logic              boundary,
    output logic [SLOT_W-1:0] next_slot,
    output logic              fsync
);
    localparam int BIT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

    logic              started_q;
    logic [BIT_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CNT_W-1:0]  slot_ext;
    logic              last_slot;

    always_comb begin
        slot_ext  = CNT_W'(slot_q);
        last_slot = (CNT_W'(slot_ext + CNT_W'(1)) >= num_slots);
        boundary  = bit_tick && (!started_q || bit_q == LAST_BIT);
        next_slot = (!started_q || last_slot) ? '0 : SLOT_W'(slot_q + SLOT_W'(1));
        fsync     = started_q && (slot_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            bit_q     <= '0;
            slot_q    <= '0;
        end else if (boundary) begin
            started_q <= 1'b1;
            bit_q     <= '0;
            slot_q    <= next_slot;
        end else if (bit_tick) begin
            bit_q     <= BIT_W'(bit_q + BIT_W'(1));
        end
    end

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick && started_q && (bit_q != LAST_BIT) |=> bit_q == BIT_W'($past(bit_q) + BIT_W'(1))); // R2
    AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick && !started_q |=> fsync); // R2
endmodule

// File: rtl/tdm_tx_ctl.sv
module tdm_tx_ctl
    import tdm_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    input  logic slot_on,
    input  logic wr_data,
    input  logic wr_slot,
    input  logic rd_status,
    input  logic tie,
    output logic load,
    output logic oe,
    output logic tde,
    output logic tue,
    output logic irq
);
    tx_state_e state_q, state_d;
    logic data_pend_q, slot_pend_q, armed_q;
    logic underrun_evt;

    // next-state decision, taken only on word boundaries
    always_comb begin
        state_d = state_q;
        if (boundary) begin
            if (!slot_on)                        state_d = ST_MUTE;
            else if (!data_pend_q && slot_pend_q) state_d = ST_HOLD;
            else                                  state_d = ST_DRIVE;
        end
        underrun_evt = boundary && slot_on && !data_pend_q && !slot_pend_q;
        load         = boundary && (state_d == ST_DRIVE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  oe = 1'b0;
            ST_DRIVE: oe = 1'b1;
            ST_MUTE:  oe = 1'b0;
            ST_HOLD:  oe = 1'b0;
        endcase
        irq = tde && tie;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_pend_q <= 1'b0;
            slot_pend_q <= 1'b0;
            armed_q     <= 1'b0;
            tde         <= 1'b0;
            tue         <= 1'b0;
        end else begin
            if (boundary && slot_on) begin
                data_pend_q <= 1'b0;
                slot_pend_q <= 1'b0;
            end
            if (wr_data) data_pend_q <= 1'b1;
            if (wr_slot) slot_pend_q <= 1'b1;

            if (wr_data || wr_slot)       tde <= 1'b0;
            else if (boundary && slot_on) tde <= 1'b1;

            if (underrun_evt)             tue <= 1'b0 | 1'b1;
            else if (wr_data && armed_q)  tue <= 1'b0;

            if (wr_data)                  armed_q <= 1'b0;
            else if (rd_status && tue)    armed_q <= 1'b1;
        end
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && !slot_on |=> !oe); // R3
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(oe)); // R3
    AST_TDE_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && slot_on && !wr_data && !wr_slot |=> tde); // R5
    AST_WRITE_CLEARS_TDE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data || wr_slot |=> !tde); // R6
    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && slot_on && slot_pend_q && !data_pend_q |=> !oe && (tue == $past(tue))); // R7
    AST_UNDERRUN_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_evt |=> tue && oe); // R8
    AST_TUE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tue && !wr_data |=> tue); // R9
endmodule

// File: rtl/tdm_tx_shift.sv
module tdm_tx_shift #(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 load,
    input  logic                 wr_data,
    input  logic [WORD_BITS-1:0] wdata,
    input  logic                 oe,
    output logic                 sdo
);
    logic [WORD_BITS-1:0] dreg_q;
    logic [WORD_BITS-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dreg_q  <= '0;
            shreg_q <= '0;
        end else begin
            if (wr_data) dreg_q <= wdata;
            if (load)
                shreg_q <= dreg_q;
            else if (bit_tick)
                shreg_q <= {shreg_q[WORD_BITS-2:0], 1'b0};
        end
    end

    assign sdo = oe && shreg_q[WORD_BITS-1];

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick && !load |=> shreg_q == {$past(shreg_q[WORD_BITS-2:0]), 1'b0}); // R4
    AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> shreg_q == $past(dreg_q)); // R8
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx #(
    parameter int MAX_SLOTS = 8,
    parameter int WORD_BITS = 8,
    localparam int SLOT_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int CNT_W  = $clog2(MAX_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic [CNT_W-1:0]     num_slots,
    input  logic [MAX_SLOTS-1:0] slot_mask,
    input  logic                 tie,
    input  logic                 wr_data,
    input  logic [WORD_BITS-1:0] wdata,
    input  logic                 wr_slot,
    input  logic                 rd_status,
    output logic                 sdo,
    output logic                 sdo_oe,
    output logic                 fsync,
    output logic                 tde,
    output logic                 tue,
    output logic                 irq
);
    logic              boundary;
    logic [SLOT_W-1:0] next_slot;
    logic              slot_on;
    logic              load;

    assign slot_on = slot_mask[next_slot];

    tdm_tx_seq #(.MAX_SLOTS(MAX_SLOTS), .WORD_BITS(WORD_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .num_slots(num_slots),
        .boundary(boundary), .next_slot(next_slot), .fsync(fsync)
    );

    tdm_tx_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .slot_on(slot_on),
        .wr_data(wr_data), .wr_slot(wr_slot), .rd_status(rd_status), .tie(tie),
        .load(load), .oe(sdo_oe), .tde(tde), .tue(tue), .irq(irq)
    );

    tdm_tx_shift #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .load(load),
        .wr_data(wr_data), .wdata(wdata), .oe(sdo_oe), .sdo(sdo)
    );

    AST_RELEASED_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo); // R3
endmodule

// File: tb/tdm_slot_tx_bench.sv
module tdm_slot_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [3:0] num_slots = 4'd5;
    logic [7:0] slot_mask = 8'h00;
    logic       tie = 1'b0;
    logic       wr_data = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       wr_slot = 1'b0;
    logic       rd_status = 1'b0;
    logic       sdo, sdo_oe, fsync, tde, tue, irq;

    int n_checks = 0;
    int n_err = 0;

    // bench model state
    bit       m_dp, m_sp, m_tde, m_tue, m_armed;
    bit [7:0] m_dreg;

    always #5 clk = ~clk;

    tdm_slot_tx u_tdm_slot_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .num_slots(num_slots),
        .slot_mask(slot_mask), .tie(tie), .wr_data(wr_data), .wdata(wdata),
        .wr_slot(wr_slot), .rd_status(rd_status), .sdo(sdo), .sdo_oe(sdo_oe),
        .fsync(fsync), .tde(tde), .tue(tue), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        bit_tick = 1'b1;
        @(posedge clk); #1;
        bit_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic host(input bit d, input bit s, input bit r, input logic [7:0] v);
        wr_data = d; wr_slot = s; rd_status = r; wdata = v;
        @(posedge clk); #1;
        wr_data = 1'b0; wr_slot = 1'b0; rd_status = 1'b0;
        @(negedge clk);
        if (d) begin
            if (m_armed) m_tue = 1'b0;
            m_armed = 1'b0;
            m_dreg  = v;
            m_dp    = 1'b1;
        end else if (r && m_tue) begin
            m_armed = 1'b1;
        end
        if (s) m_sp = 1'b1;
        if (d || s) m_tde = 1'b0;
    endtask

    task automatic do_reset(input int ns);
        rst_n = 1'b0;
        num_slots = 4'(ns);
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", sdo_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", {sdo_oe, sdo, fsync, tde, tue, irq}, 0);
        m_dp = 0; m_sp = 0; m_tde = 0; m_tue = 0; m_armed = 0; m_dreg = 8'h00;
    endtask

    initial begin
        #1_500_000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int cfg = 0; cfg < 3; cfg++) begin
            int ns;
            ns = (cfg == 0) ? 5 : (cfg == 1) ? 3 : 1;
            for (int mask = 0; mask < (1 << ns); mask++) begin
                slot_mask = 8'(mask);
                tie = (mask % 3) != 0;
                do_reset(ns);
                host(1'b1, 1'b0, 1'b0, 8'(mask * 29 + 8'h5A));
                for (int f = 0; f < 2; f++) begin
                    for (int s = 0; s < ns; s++) begin
                        bit        e_oe;
                        bit [7:0]  word;
                        string     tag;
                        int        act;
                        word = 8'h00;
                        e_oe = 1'b0;
                        if (mask[s]) begin
                            if (m_dp) begin
                                tag  = m_sp ? "R10 both written" : "R4 fresh word";
                                e_oe = 1'b1;
                            end else if (m_sp) begin
                                tag = "R7 slot-only hold";
                            end else begin
                                tag   = "R8 underrun resend";
                                e_oe  = 1'b1;
                                m_tue = 1'b1;
                            end
                            m_dp = 0; m_sp = 0; m_tde = 1;
                            word = m_dreg;
                        end else begin
                            tag = "R3 masked slot";
                        end
                        tick();
                        chk("R2 fsync", fsync, (s == 0));
                        chk("R5 tde at slot start", tde, m_tde);
                        chk("R5 irq", irq, m_tde && tie);
                        chk("R8 tue at slot start", tue, m_tue);
                        for (int b = 7; b >= 0; b--) begin
                            if (b < 7) tick();
                            chk(tag, {sdo_oe, sdo}, {e_oe, e_oe & word[b]});
                            if (b == 7) begin
                                logic [7:0] v;
                                v   = 8'(mask * 29 + s * 13 + f * 71 + 8'h5A);
                                act = (mask * 7 + s * 3 + f * 5 + ns) % 6;
                                case (act)
                                    1: host(1'b1, 1'b0, 1'b0, v);
                                    2: host(1'b0, 1'b1, 1'b0, v);
                                    3: host(1'b1, 1'b1, 1'b0, v);
                                    4: begin
                                        host(1'b0, 1'b0, 1'b1, v);
                                        host(1'b1, 1'b0, 1'b0, v);
                                    end
                                    5: host(1'b0, 1'b0, 1'b1, v);
                                    default: ;
                                endcase
                                chk("R6 tde after host action", tde, m_tde);
                                chk("R9 tue after host action", tue, m_tue);
                                chk("R5 irq after host action", irq, m_tde && tie);
                            end
                        end
                        chk("R2 fsync held through word", fsync, (s == 0));
                    end
                end
            end
        end
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule